// File: doc/BRIEF.md
# Processor-Mapped Eight-Pin I/O Port

This block is one 8-bit I/O port slice that a processor reaches through a window of eight register offsets. The processor can set the level each pin drives and choose which pins drive. It can also load and read a bank of output macrocell flip-flops that programmable logic normally updates. The processor can read back the synchronized pin levels, a bank of input macrocell latches and the enable that actually reaches each pin driver.

A pin's driver is switched on by the OR of its software direction bit and an enable term supplied from outside, per pin. The processor can read that combined enable at its own offset. The output macrocells take a next-state value from the logic side whenever the logic side strobes its load input, but a processor write to the same offset in the same cycle wins. The input macrocells follow the synchronized pins while a capture enable is high and hold when it is low. They feed both a read offset and an output bus toward the logic array.

The bus is synchronous: read data is registered and appears one clock after the read strobe, and it holds until the next read. Pad inputs pass through a synchronizer of at least two flops before any internal use.

Top module: `gpio_port_regs`

## Requirements
- R1: A synchronous active-high reset clears the output level register, the direction register, both macrocell banks, the synchronizer and the read data to zero. After reset, pad_oe equals ext_oe.
- R2: pad_oe bit i is 1 exactly when direction bit i (offset 2) is 1 or ext_oe bit i is 1.
- R3: A write to offset 1 stores the value. From the next clock, pad_out shows the stored value, and a read of offset 1 returns it rather than the pin level.
- R4: A read of offset 0 returns the pad levels after the synchronizer. With two stages, a pad change made together with the read strobe is not yet visible, and it becomes visible a few cycles later.
- R5: A read of offset 5 returns the per-pin OR of the direction bit and ext_oe, as presented on pad_oe.
- R6: A write to offset 3 loads the output macrocells. A read of offset 3 and the mc_out port both show the flip-flop values.
- R7: While plm_load is high, the output macrocells take plm_next. If a processor write to offset 3 happens in the same cycle, the written data is stored instead.
- R8: On each clock with cap_en high, the input macrocells take the synchronized pad levels. With cap_en low they hold. Their value shows on plm_in_bus and at read offset 4.
- R9: Writes to offsets 0, 4, 5, 6 and 7 change no register. Reads of offsets 6 and 7 return zero.
- R10: bus_rdata changes only on the clock after a read strobe. Without a read strobe, it holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Level each pin drives when enabled |
| pad_oe | output | 8 | Per-pin driver enable |
| ext_oe | input | 8 | Per-pin enable term from the logic array |
| plm_load | input | 1 | Logic-side load strobe for output macrocells |
| plm_next | input | 8 | Logic-side next state for output macrocells |
| mc_out | output | 8 | Output macrocell flip-flop values |
| cap_en | input | 1 | Input macrocell capture enable |
| plm_in_bus | output | 8 | Input macrocell values toward the logic array |

## Verification
The hardest case to reach from the ports is a clock in which the logic-side load and a processor write to the output macrocells coincide. The stimulus raises plm_load and the write strobe on the same falling edge, with different data on each, and then reads offset 3. A second hard case is an input macrocell value that was captured and then held while the pins moved. To set this up, the stimulus captures one pattern, drops cap_en, changes the pads, lets the synchronizer settle, and only then reads offset 4.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int OFF_PIN  = 0;
   localparam int OFF_DOUT = 1;
   localparam int OFF_DIR  = 2;
   localparam int OFF_OMC  = 3;
   localparam int OFF_IMC  = 4;
   localparam int OFF_OEV  = 5;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= '0;
               else     chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= '0;
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic [WIDTH-1:0]  ext_oe,
   output logic [WIDTH-1:0]  dout_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  oe_eff
);
   import gpio_port_pkg::*;

   logic we_dout, we_dir;
   assign we_dout = bus_wr && (bus_addr == ADDR_W'(OFF_DOUT));
   assign we_dir  = bus_wr && (bus_addr == ADDR_W'(OFF_DIR));

   always_ff @(posedge clk) begin
      if (rst) begin
         dout_q <= '0;
         dir_q  <= '0;
      end else begin
         if (we_dout) dout_q <= bus_wdata;
         if (we_dir)  dir_q  <= bus_wdata;
      end
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_oe
         assign oe_eff[i] = dir_q[i] | ext_oe[i];
      end
   endgenerate

   // R1: reset empties both control registers
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (dout_q == '0 && dir_q == '0));

   // R9: read-only offsets leave control registers untouched
   p_ro_ignored_r9: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr != ADDR_W'(OFF_DOUT) && bus_addr != ADDR_W'(OFF_DIR))
      |=> ($stable(dout_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_macrocell_bank.sv
module gpio_macrocell_bank #(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic              plm_load,
   input  logic [WIDTH-1:0]  plm_next,
   input  logic              cap_en,
   input  logic [WIDTH-1:0]  pin_sync,
   output logic [WIDTH-1:0]  omc_q,
   output logic [WIDTH-1:0]  imc_q
);
   import gpio_port_pkg::*;

   logic we_omc;
   assign we_omc = bus_wr && (bus_addr == ADDR_W'(OFF_OMC));

   always_ff @(posedge clk) begin
      if (rst)           omc_q <= '0;
      else if (we_omc)   omc_q <= bus_wdata;
      else if (plm_load) omc_q <= plm_next;
   end

   always_ff @(posedge clk) begin
      if (rst)         imc_q <= '0;
      else if (cap_en) imc_q <= pin_sync;
   end

   // R7: processor write wins over the logic-side load
   p_bus_wins_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(OFF_OMC)) |=> (omc_q == $past(bus_wdata)));

   // R7: logic-side load alone takes plm_next
   p_plm_load_r7: assert property (@(posedge clk) disable iff (rst)
      (plm_load && !(bus_wr && bus_addr == ADDR_W'(OFF_OMC)))
      |=> (omc_q == $past(plm_next)));

   // R8: input macrocells hold without capture enable
   p_imc_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !cap_en |=> $stable(imc_q));
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux #(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  pin_sync,
   input  logic [WIDTH-1:0]  dout_q,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic [WIDTH-1:0]  omc_q,
   input  logic [WIDTH-1:0]  imc_q,
   input  logic [WIDTH-1:0]  oe_eff,
   output logic [WIDTH-1:0]  bus_rdata
);
   import gpio_port_pkg::*;

   logic [WIDTH-1:0] sel;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFF_PIN))  sel = pin_sync;
      else if (bus_addr == ADDR_W'(OFF_DOUT)) sel = dout_q;
      else if (bus_addr == ADDR_W'(OFF_DIR))  sel = dir_q;
      else if (bus_addr == ADDR_W'(OFF_OMC))  sel = omc_q;
      else if (bus_addr == ADDR_W'(OFF_IMC))  sel = imc_q;
      else if (bus_addr == ADDR_W'(OFF_OEV))  sel = oe_eff;
      else                                    sel = '0;
   end

   always_ff @(posedge clk) begin
      if (rst)         bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= sel;
   end

   // R10: read data moves only after a read strobe
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   input  logic [WIDTH-1:0]  ext_oe,
   input  logic              plm_load,
   input  logic [WIDTH-1:0]  plm_next,
   output logic [WIDTH-1:0]  mc_out,
   input  logic              cap_en,
   output logic [WIDTH-1:0]  plm_in_bus
);
   import gpio_port_pkg::*;

   initial begin
      assert (WIDTH >= 1)  else $error("WIDTH must be positive");
      assert (ADDR_W >= 3) else $error("ADDR_W must cover six offsets");
   end

   logic [WIDTH-1:0] pin_sync, dout_q, dir_q, oe_eff, omc_q, imc_q;

   gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync));

   gpio_ctrl_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_ctrl (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .ext_oe(ext_oe), .dout_q(dout_q),
      .dir_q(dir_q), .oe_eff(oe_eff));

   gpio_macrocell_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_mc (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .plm_load(plm_load), .plm_next(plm_next),
      .cap_en(cap_en), .pin_sync(pin_sync), .omc_q(omc_q), .imc_q(imc_q));

   gpio_rd_mux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_rd (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .pin_sync(pin_sync), .dout_q(dout_q), .dir_q(dir_q), .omc_q(omc_q),
      .imc_q(imc_q), .oe_eff(oe_eff), .bus_rdata(bus_rdata));

   assign pad_out    = dout_q;
   assign pad_oe     = oe_eff;
   assign mc_out     = omc_q;
   assign plm_in_bus = imc_q;

   // R2: a direction write switches those drivers on next cycle
   p_dir_drives_oe_r2: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(OFF_DIR))
      |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

   // R3: level write reaches pad_out next cycle
   p_dout_to_pad_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(OFF_DOUT)) |=> (pad_out == $past(bus_wdata)));

   // R4: pin read returns synchronized level
   p_pin_read_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == ADDR_W'(OFF_PIN)) |=> (bus_rdata == $past(pin_sync)));

   // R5: enable view read matches the driver enable
   p_oe_view_r5: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == ADDR_W'(OFF_OEV)) |=> (bus_rdata == $past(pad_oe)));
endmodule

// File: tb/test_gpio_port_regs.sv
module test_gpio_port_regs;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] pad_in = '0, pad_out, pad_oe, ext_oe = '0;
   logic       plm_load = 1'b0, cap_en = 1'b0;
   logic [7:0] plm_next = '0, mc_out, plm_in_bus;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   gpio_port_regs i_gpio_port_regs (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .ext_oe(ext_oe),
      .plm_load(plm_load), .plm_next(plm_next), .mc_out(mc_out),
      .cap_en(cap_en), .plm_in_bus(plm_in_bus));

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string tag);
      exp_t item;
      @(negedge clk);
      item.val = e; item.tag = tag;
      sb.push_back(item);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops one expectation per read strobe seen at a rising edge
   initial begin
      forever begin
         @(posedge clk);
         if (bus_rd && !rst) begin
            @(negedge clk);
            if (sb.size() == 0) begin
               check(bus_rdata, 8'hxx, "scoreboard underflow");
            end else begin
               exp_t item;
               item = sb.pop_front();
               check(bus_rdata, item.val, item.tag);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk); rst = 1'b0;
      // R1 reset state
      check(pad_oe, 8'h00, "R1 pad_oe after reset");
      bus_read(3'd1, 8'h00, "R1 data out cleared");
      bus_read(3'd2, 8'h00, "R1 direction cleared");
      bus_read(3'd3, 8'h00, "R1 output macrocells cleared");
      bus_read(3'd4, 8'h00, "R1 input macrocells cleared");

      // R3 level register
      bus_write(3'd1, 8'hA5);
      check(pad_out, 8'hA5, "R3 pad_out follows write");
      pad_in = 8'h3C;
      idle(4);
      bus_read(3'd1, 8'hA5, "R3 readback is register not pin");

      // R2 / R5 enable combination
      ext_oe = 8'h30;
      bus_write(3'd2, 8'h0F);
      check(pad_oe, 8'h3F, "R2 pad_oe is dir OR ext");
      bus_read(3'd5, 8'h3F, "R5 enable view");
      ext_oe = 8'h81;
      @(negedge clk);
      check(pad_oe, 8'h8F, "R2 ext term alone enables");
      bus_read(3'd5, 8'h8F, "R5 enable view ext change");

      // R4 pin path
      bus_read(3'd0, 8'h3C, "R4 settled pin read");
      @(negedge clk);
      begin
         exp_t item;
         item.val = 8'h3C; item.tag = "R4 sync latency hides new level";
         sb.push_back(item);
      end
      pad_in = 8'hC3; bus_addr = 3'd0; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0;
      idle(3);
      bus_read(3'd0, 8'hC3, "R4 new level after sync");

      // R6 output macrocell
      bus_write(3'd3, 8'h5A);
      check(mc_out, 8'h5A, "R6 mc_out after write");
      bus_read(3'd3, 8'h5A, "R6 macrocell readback");

      // R7 logic-side load and collision
      @(negedge clk); plm_next = 8'h33; plm_load = 1'b1;
      @(negedge clk); plm_load = 1'b0;
      check(mc_out, 8'h33, "R7 logic load");
      bus_read(3'd3, 8'h33, "R7 logic load readback");
      @(negedge clk);
      plm_next = 8'h77; plm_load = 1'b1;
      bus_addr = 3'd3; bus_wdata = 8'h99; bus_wr = 1'b1;
      @(negedge clk); plm_load = 1'b0; bus_wr = 1'b0;
      bus_read(3'd3, 8'h99, "R7 processor write wins");

      // R8 input macrocells capture and hold
      pad_in = 8'h96; idle(3);
      cap_en = 1'b1; idle(2);
      cap_en = 1'b0;
      pad_in = 8'h11; idle(4);
      check(plm_in_bus, 8'h96, "R8 held on bus");
      bus_read(3'd4, 8'h96, "R8 held readback");
      cap_en = 1'b1; idle(2); cap_en = 1'b0;
      bus_read(3'd4, 8'h11, "R8 new capture");

      // R9 read-only offsets ignore writes
      bus_write(3'd0, 8'hFF);
      bus_write(3'd4, 8'hFF);
      bus_write(3'd5, 8'hFF);
      bus_write(3'd6, 8'hFF);
      bus_write(3'd7, 8'hFF);
      check(pad_out, 8'hA5, "R9 pad_out unchanged");
      check(pad_oe, 8'h8F, "R9 pad_oe unchanged");
      bus_read(3'd2, 8'h0F, "R9 direction unchanged");
      bus_read(3'd3, 8'h99, "R9 macrocells unchanged");
      bus_read(3'd4, 8'h11, "R9 input macrocells unchanged");
      bus_read(3'd6, 8'h00, "R9 offset 6 reads zero");
      bus_read(3'd7, 8'h00, "R9 offset 7 reads zero");

      // R10 read data holds without strobe
      bus_read(3'd1, 8'hA5, "R10 read before hold");
      bus_write(3'd1, 8'h42);
      idle(3);
      check(bus_rdata, 8'hA5, "R10 rdata held without strobe");

      // R1 mid-run reset
      ext_oe = 8'h00;
      @(negedge clk); rst = 1'b1;
      idle(2);
      @(negedge clk); rst = 1'b0;
      check(pad_oe, 8'h00, "R1 pad_oe after second reset");
      check(pad_out, 8'h00, "R1 pad_out after second reset");
      check(mc_out, 8'h00, "R1 mc_out after second reset");
      check(bus_rdata, 8'h00, "R1 rdata after second reset");

      idle(3);
      check(8'(sb.size()), 8'h00, "scoreboard drained");
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule